// File: doc/BRIEF.md
# Operation Arm and Trigger Context

This block keeps, for each processor attached to a copy and messaging engine, a small control context that decides whether the engine's setup registers may be programmed and whether a started operation must be dropped. Each context holds an Armed flag, a Triggered flag, a command Ready flag, a purge-detected flag and a purge-abort enable. The number of contexts is a parameter and defaults to two, one per processor.

Software arms a context and then loads the command, page frame and offset registers. Those loads are let through only while the context is armed and not yet marked ready. When software issues an operation, the Armed/Triggered pair moves by one rule. When a TLB purge is seen anywhere in the system, the pair moves by a second rule and every context records that a purge happened. When the engine starts work, the block reports in the same cycle whether the start must be aborted. An aborted start is reported with error code zero.

The reset input is asynchronous and active low. The block synchronises its release internally, so the state leaves reset two clock edges after `rst_n` rises.

Top module: `arm_ctx_top`

## Requirements
- R1: While reset is applied, every context reads Armed, Triggered, Ready, purge-seen and purge-abort-enable as 0. These values appear as soon as reset is asserted.
- R2: An issue strobe alone changes the (Triggered, Armed) pair at the next edge as follows: (0,1) becomes (1,0), (1,0) becomes (0,0), and (0,0) and (1,1) are kept.
- R3: A TLB purge alone clears the pair from (0,1) to (0,0) at the next edge. It keeps (0,0), (1,0) and (1,1).
- R4: When an issue strobe and a TLB purge arrive in the same cycle, the purge rule is applied first and the issue rule is then applied to its result.
- R5: A context register write sets Armed to the written value. A written Triggered bit of 0 clears Triggered, and a written 1 leaves it unchanged. Hardware alone sets Triggered, and only an issue strobe can raise it. In the same cycle, the software write overrides the hardware result for both bits.
- R6: The command, page-frame and offset write enables are asserted in the same cycle as the request, and only while the context is armed and not ready. A command write made outside that window changes no state.
- R7: An accepted command write loads Ready, purge-abort-enable and the purge-seen clear at the next edge. An engine-consumed strobe clears Ready at the next edge.
- R8: A TLB purge sets purge-seen in every context at the next edge. An accepted command write with purge-seen written 0 clears it, and this clear wins over a purge in the same cycle. Writing 1 does not set it.
- R9: The start-abort output is high in the same cycle as an engine start only when that context's purge-seen and purge-abort-enable are both 1. An aborted start is reported with error code 0.
- R10: The contexts are independent. Strobes for one context leave the other's state unchanged, except that a purge is broadcast to all contexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_purge | input | 1 | TLB purge/invalidate detected, broadcast to all contexts |
| ctx_we | input | N_CTX | Software write to a context register |
| ctx_wd_arm | input | N_CTX | Armed value written |
| ctx_wd_trig | input | N_CTX | Triggered value written (0 clears) |
| op_issue | input | N_CTX | Operation issued by the processor |
| cmd_we | input | N_CTX | Command register write request |
| cmd_wd_ready | input | N_CTX | Ready value in the command write |
| cmd_wd_abort_en | input | N_CTX | Purge-abort-enable value in the command write |
| cmd_wd_purge_seen | input | N_CTX | Purge-seen value in the command write (0 clears) |
| pf_we | input | N_CTX | Page-frame register write request |
| ofs_we | input | N_CTX | Offset register write request |
| eng_consumed | input | N_CTX | Engine has read all setup registers |
| eng_start | input | N_CTX | Engine is starting the operation |
| armed | output | N_CTX | Armed flag |
| triggered | output | N_CTX | Triggered flag |
| ready | output | N_CTX | Command Ready flag |
| purge_seen | output | N_CTX | Purge-detected flag |
| abort_en | output | N_CTX | Purge-abort enable |
| cmd_wr_en | output | N_CTX | Qualified command register write enable |
| pf_wr_en | output | N_CTX | Qualified page-frame register write enable |
| ofs_wr_en | output | N_CTX | Qualified offset register write enable |
| start_abort | output | N_CTX | Abort the start being requested (error code 0) |

## Verification
The flag outputs are registered. A strobe driven in one cycle is seen on the flags one edge later, so the bench drives each table row at a falling edge, returns the inputs to idle at the next falling edge, and compares the flags at that moment. The write enables and start-abort are combinational from the current state. They are sampled 1 ns after the request is driven, within the same cycle, and before the next edge can change the state. Reset is checked while it is held, because its effect on the flags does not wait for a clock edge.

// File: rtl/arm_ctx_pkg.sv
package arm_ctx_pkg;
  // Armed/Triggered pair of one context
  typedef struct packed {
    logic trig;
    logic armed;
  } at_pair_t;
endpackage

// File: rtl/arm_ctx_pair_next.sv
module arm_ctx_pair_next
  import arm_ctx_pkg::*;
(
  input  at_pair_t cur,
  input  logic     tlb,
  input  logic     issue,
  input  logic     sw_we,
  input  logic     sw_arm,
  input  logic     sw_trig,
  output at_pair_t nxt
);
  at_pair_t after_tlb;
  at_pair_t after_iss;

  always_comb begin
    // purge rule first: only an armed, untriggered context is disarmed
    after_tlb = cur;
    if (tlb && cur.armed && !cur.trig) begin
      after_tlb = '0;
    end
    // issue rule applied to the purge result
    after_iss = after_tlb;
    if (issue) begin
      case ({after_tlb.trig, after_tlb.armed})
        2'b01:   after_iss = '{trig: 1'b1, armed: 1'b0};
        2'b10:   after_iss = '0;
        default: after_iss = after_tlb;
      endcase
    end
    // software owns Armed and the clearing of Triggered
    nxt = after_iss;
    if (sw_we) begin
      nxt.armed = sw_arm;
      nxt.trig  = after_iss.trig & sw_trig;
    end
  end
endmodule

// File: rtl/arm_ctx_slot.sv
module arm_ctx_slot
  import arm_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tlb,
  input  logic ctx_we,
  input  logic ctx_wd_arm,
  input  logic ctx_wd_trig,
  input  logic issue,
  input  logic cmd_we,
  input  logic cmd_wd_ready,
  input  logic cmd_wd_abort_en,
  input  logic cmd_wd_purge_seen,
  input  logic pf_we,
  input  logic ofs_we,
  input  logic consumed,
  input  logic start,
  output logic armed_o,
  output logic trig_o,
  output logic ready_o,
  output logic purge_seen_o,
  output logic abort_en_o,
  output logic cmd_wr_en_o,
  output logic pf_wr_en_o,
  output logic ofs_wr_en_o,
  output logic start_abort_o
);
  at_pair_t pair_q, pair_d;
  logic     ready_q, ready_d;
  logic     ps_q, ps_d;
  logic     ae_q, ae_d;
  logic     setup_ok;
  logic     cmd_acc;
  logic     upd_en;

  arm_ctx_pair_next u_pair (
    .cur     (pair_q),
    .tlb     (tlb),
    .issue   (issue),
    .sw_we   (ctx_we),
    .sw_arm  (ctx_wd_arm),
    .sw_trig (ctx_wd_trig),
    .nxt     (pair_d)
  );

  always_comb begin
    setup_ok = pair_q.armed & ~ready_q;
    cmd_acc  = cmd_we & setup_ok;
    ready_d  = ready_q;
    if (cmd_acc) begin
      ready_d = cmd_wd_ready;
    end else if (consumed) begin
      ready_d = 1'b0;
    end
    ps_d   = (ps_q | tlb) & (~cmd_acc | cmd_wd_purge_seen);
    ae_d   = cmd_acc ? cmd_wd_abort_en : ae_q;
    upd_en = tlb | ctx_we | issue | cmd_acc | consumed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      ready_q <= 1'b0;
      ps_q    <= 1'b0;
      ae_q    <= 1'b0;
    end else if (upd_en) begin
      pair_q  <= pair_d;
      ready_q <= ready_d;
      ps_q    <= ps_d;
      ae_q    <= ae_d;
    end
  end

  assign armed_o       = pair_q.armed;
  assign trig_o        = pair_q.trig;
  assign ready_o       = ready_q;
  assign purge_seen_o  = ps_q;
  assign abort_en_o    = ae_q;
  assign cmd_wr_en_o   = cmd_acc;
  assign pf_wr_en_o    = pf_we & setup_ok;
  assign ofs_wr_en_o   = ofs_we & setup_ok;
  assign start_abort_o = start & ps_q & ae_q;
endmodule

// File: rtl/arm_ctx_top.sv
module arm_ctx_top #(
  parameter int N_CTX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tlb_purge,
  input  logic [N_CTX-1:0] ctx_we,
  input  logic [N_CTX-1:0] ctx_wd_arm,
  input  logic [N_CTX-1:0] ctx_wd_trig,
  input  logic [N_CTX-1:0] op_issue,
  input  logic [N_CTX-1:0] cmd_we,
  input  logic [N_CTX-1:0] cmd_wd_ready,
  input  logic [N_CTX-1:0] cmd_wd_abort_en,
  input  logic [N_CTX-1:0] cmd_wd_purge_seen,
  input  logic [N_CTX-1:0] pf_we,
  input  logic [N_CTX-1:0] ofs_we,
  input  logic [N_CTX-1:0] eng_consumed,
  input  logic [N_CTX-1:0] eng_start,
  output logic [N_CTX-1:0] armed,
  output logic [N_CTX-1:0] triggered,
  output logic [N_CTX-1:0] ready,
  output logic [N_CTX-1:0] purge_seen,
  output logic [N_CTX-1:0] abort_en,
  output logic [N_CTX-1:0] cmd_wr_en,
  output logic [N_CTX-1:0] pf_wr_en,
  output logic [N_CTX-1:0] ofs_wr_en,
  output logic [N_CTX-1:0] start_abort
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
    arm_ctx_slot u_slot (
      .clk               (clk),
      .rst_n             (rst_sync_n),
      .tlb               (tlb_purge),
      .ctx_we            (ctx_we[g]),
      .ctx_wd_arm        (ctx_wd_arm[g]),
      .ctx_wd_trig       (ctx_wd_trig[g]),
      .issue             (op_issue[g]),
      .cmd_we            (cmd_we[g]),
      .cmd_wd_ready      (cmd_wd_ready[g]),
      .cmd_wd_abort_en   (cmd_wd_abort_en[g]),
      .cmd_wd_purge_seen (cmd_wd_purge_seen[g]),
      .pf_we             (pf_we[g]),
      .ofs_we            (ofs_we[g]),
      .consumed          (eng_consumed[g]),
      .start             (eng_start[g]),
      .armed_o           (armed[g]),
      .trig_o            (triggered[g]),
      .ready_o           (ready[g]),
      .purge_seen_o      (purge_seen[g]),
      .abort_en_o        (abort_en[g]),
      .cmd_wr_en_o       (cmd_wr_en[g]),
      .pf_wr_en_o        (pf_wr_en[g]),
      .ofs_wr_en_o       (ofs_wr_en[g]),
      .start_abort_o     (start_abort[g])
    );
  end
endmodule

// File: rtl/arm_ctx_chk.sv
module arm_ctx_chk #(
  parameter int N_CTX = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tlb_purge,
  input logic [N_CTX-1:0] ctx_we,
  input logic [N_CTX-1:0] op_issue,
  input logic [N_CTX-1:0] eng_consumed,
  input logic [N_CTX-1:0] eng_start,
  input logic [N_CTX-1:0] armed,
  input logic [N_CTX-1:0] triggered,
  input logic [N_CTX-1:0] ready,
  input logic [N_CTX-1:0] purge_seen,
  input logic [N_CTX-1:0] abort_en,
  input logic [N_CTX-1:0] cmd_wr_en,
  input logic [N_CTX-1:0] pf_wr_en,
  input logic [N_CTX-1:0] ofs_wr_en,
  input logic [N_CTX-1:0] start_abort
);
  for (genvar i = 0; i < N_CTX; i++) begin : g_chk
    p_issue_fire_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      op_issue[i] && armed[i] && !triggered[i] && !tlb_purge && !ctx_we[i]
      |=> triggered[i] && !armed[i]);

    p_purge_disarm_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      tlb_purge && armed[i] && !triggered[i] && !ctx_we[i]
      |=> !armed[i] && !triggered[i]);

    p_trig_source_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !op_issue[i] |=> !$rose(triggered[i]));

    p_setup_gate_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmd_wr_en[i] || pf_wr_en[i] || ofs_wr_en[i]) |-> armed[i] && !ready[i]);

    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ready[i] && eng_consumed[i] |=> !ready[i]);

    p_purge_flag_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      tlb_purge && !cmd_wr_en[i] |=> purge_seen[i]);

    p_start_abort_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      start_abort[i] |-> eng_start[i] && purge_seen[i] && abort_en[i]);
  end
endmodule

bind arm_ctx_top arm_ctx_chk #(.N_CTX(N_CTX)) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .tlb_purge    (tlb_purge),
  .ctx_we       (ctx_we),
  .op_issue     (op_issue),
  .eng_consumed (eng_consumed),
  .eng_start    (eng_start),
  .armed        (armed),
  .triggered    (triggered),
  .ready        (ready),
  .purge_seen   (purge_seen),
  .abort_en     (abort_en),
  .cmd_wr_en    (cmd_wr_en),
  .pf_wr_en     (pf_wr_en),
  .ofs_wr_en    (ofs_wr_en),
  .start_abort  (start_abort)
);

// File: tb/arm_ctx_top_tb.sv
module arm_ctx_top_tb_top;
  localparam int N = 2;
  localparam int NV = 22;

  // row: [14]tlb [13]ctx_we [12]wd_arm [11]wd_trig [10]issue [9]cmd_we
  //      [8]wd_ready [7]wd_abort_en [6]wd_purge_seen [5]consumed
  //      expected after the edge: [4]T [3]A [2]Ready [1]PurgeSeen [0]AbortEn
  localparam logic [14:0] VEC [NV] = '{
    15'b0_1100_00000_01000, // R5 arm
    15'b0_0001_00000_10000, // R2 01->10
    15'b0_0001_00000_00000, // R2 10->00
    15'b0_1100_00000_01000, // R5 arm
    15'b1_0000_00000_00010, // R3 01->00, R8 purge set
    15'b0_1110_00000_01010, // R5 writing 1 to trig does not set
    15'b0_0001_00000_10010, // R2 01->10
    15'b0_1110_00000_11010, // R5 arm keeps trig
    15'b0_0001_00000_11010, // R2 11 kept
    15'b1_0000_00000_11010, // R3 11 kept
    15'b0_1100_00000_01010, // R5 trig cleared by sw
    15'b0_0000_10100_01001, // R7 abort_en load, R8 purge clear
    15'b1_0001_00000_00011, // R4 purge then issue on 01
    15'b0_1100_00000_01011, // R5 arm
    15'b0_0000_11110_01111, // R7 ready set
    15'b0_0000_10000_01111, // R6 write while ready ignored
    15'b0_0000_00001_01011, // R7 consumed clears ready
    15'b1_0000_10100_00001, // R8 sw clear beats purge; R3 disarm
    15'b0_0000_11000_00001, // R6 write while unarmed ignored
    15'b0_1100_00000_01001, // R5 arm
    15'b0_1111_00000_11001, // R5 sw arm with hw trigger
    15'b0_1001_00000_00001  // R5 sw clear beats hw keep
  };

  logic clk = 1'b0;
  logic rst_n;
  logic tlb_purge;
  logic [N-1:0] ctx_we, ctx_wd_arm, ctx_wd_trig, op_issue;
  logic [N-1:0] cmd_we, cmd_wd_ready, cmd_wd_abort_en, cmd_wd_purge_seen;
  logic [N-1:0] pf_we, ofs_we, eng_consumed, eng_start;
  logic [N-1:0] armed, triggered, ready, purge_seen, abort_en;
  logic [N-1:0] cmd_wr_en, pf_wr_en, ofs_wr_en, start_abort;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  arm_ctx_top #(.N_CTX(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .tlb_purge(tlb_purge),
    .ctx_we(ctx_we), .ctx_wd_arm(ctx_wd_arm), .ctx_wd_trig(ctx_wd_trig),
    .op_issue(op_issue), .cmd_we(cmd_we), .cmd_wd_ready(cmd_wd_ready),
    .cmd_wd_abort_en(cmd_wd_abort_en), .cmd_wd_purge_seen(cmd_wd_purge_seen),
    .pf_we(pf_we), .ofs_we(ofs_we), .eng_consumed(eng_consumed),
    .eng_start(eng_start), .armed(armed), .triggered(triggered),
    .ready(ready), .purge_seen(purge_seen), .abort_en(abort_en),
    .cmd_wr_en(cmd_wr_en), .pf_wr_en(pf_wr_en), .ofs_wr_en(ofs_wr_en),
    .start_abort(start_abort)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] flags(input int c);
    return {triggered[c], armed[c], ready[c], purge_seen[c], abort_en[c]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tlb_purge = 1'b0;
    ctx_we = '0; ctx_wd_arm = '0; ctx_wd_trig = '0; op_issue = '0;
    cmd_we = '0; cmd_wd_ready = '0; cmd_wd_abort_en = '0; cmd_wd_purge_seen = '0;
    pf_we = '0; ofs_we = '0; eng_consumed = '0; eng_start = '0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ctx0", {3'b0, flags(0)}, 8'h00);
    chk("R1 reset ctx1", {3'b0, flags(1)}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [14:0] v;
      v = VEC[k];
      @(negedge clk);
      tlb_purge            = v[14];
      ctx_we[0]            = v[13];
      ctx_wd_arm[0]        = v[12];
      ctx_wd_trig[0]       = v[11];
      op_issue[0]          = v[10];
      cmd_we[0]            = v[9];
      cmd_wd_ready[0]      = v[8];
      cmd_wd_abort_en[0]   = v[7];
      cmd_wd_purge_seen[0] = v[6];
      eng_consumed[0]      = v[5];
      @(negedge clk);
      idle();
      chk($sformatf("R2 R3 R4 R5 R6 R7 R8 row %0d", k), {3'b0, flags(0)}, {3'b0, v[4:0]});
    end

    // ctx0 now T0 A0 R0 P0 E1; ctx1 saw the purges only
    chk("R10 ctx1 isolated", {3'b0, flags(1)}, 8'b0000_0010);

    // unarmed: no enables, command write ignored
    @(negedge clk);
    pf_we[0] = 1'b1; ofs_we[0] = 1'b1; cmd_we[0] = 1'b1;
    #1;
    chk("R6 unarmed enables", {5'b0, cmd_wr_en[0], pf_wr_en[0], ofs_wr_en[0]}, 8'h00);
    @(negedge clk);
    idle();
    chk("R6 unarmed cmd ignored", {3'b0, flags(0)}, 8'b0000_0001);

    // arm, then enables pass
    @(negedge clk);
    ctx_we[0] = 1'b1; ctx_wd_arm[0] = 1'b1;
    @(negedge clk);
    idle();
    pf_we[0] = 1'b1; ofs_we[0] = 1'b1;
    #1;
    chk("R6 armed enables", {6'b0, pf_wr_en[0], ofs_wr_en[0]}, 8'h03);
    chk("R10 ctx1 enables off", {6'b0, pf_wr_en[1], ofs_wr_en[1]}, 8'h00);

    // ready blocks further writes
    @(negedge clk);
    idle();
    cmd_we[0] = 1'b1; cmd_wd_ready[0] = 1'b1; cmd_wd_abort_en[0] = 1'b1;
    @(negedge clk);
    idle();
    pf_we[0] = 1'b1; cmd_we[0] = 1'b1;
    #1;
    chk("R6 ready blocks", {6'b0, pf_wr_en[0], cmd_wr_en[0]}, 8'h00);

    // start abort
    @(negedge clk);
    idle();
    eng_start = '1;
    #1;
    chk("R9 no purge no abort", {6'b0, start_abort}, 8'h00);
    @(negedge clk);
    idle();
    tlb_purge = 1'b1;
    @(negedge clk);
    idle();
    eng_start = '1;
    #1;
    chk("R9 abort ctx0 only", {6'b0, start_abort}, 8'h01);
    @(negedge clk);
    idle();
    chk("R8 purge seen both", {6'b0, purge_seen}, 8'h03);

    // asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run ctx0", {3'b0, flags(0)}, 8'h00);
    chk("R1 reset mid-run ctx1", {3'b0, flags(1)}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule